// File: doc/BRIEF.md
# Fused-Layer Tile Assembler with Overlap Reuse

When several convolution layers are fused, each output pyramid needs an input tile for the next layer. Part of that tile was already produced by neighbouring pyramids. Some columns were produced by the pyramid just to the left in the same row. Some rows were produced by the pyramid directly above, which belongs to the previous row of pyramids. This block builds the tile. It reads only the freshly computed values from a source tile memory and takes the overlap from two internal reuse stores. It writes the finished tile into a destination memory, one element per cycle, covering every channel. As it streams, it saves the right-edge columns and the bottom-edge rows of the tile so that later pyramids can use them.

The overlap width is `OV = KER - STR`, where `KER` is the kernel size and `STR` is the stride of the layer that consumes the tile. Consecutive pyramids are spaced `TW - OV` columns apart and `TH - OV` rows apart. A controller pulses `start` together with the pyramid's row and column position, then waits for `done`. Pyramids are visited in raster order: across a row from left to right, then down to the next row.

Top module: `pyr_tile_assembler`

## Requirements
- R1: `start` is accepted only when `busy` is low, and the position is captured at that moment. A `start` pulse while `busy` is high has no effect on the tile being built. `done` is a single-cycle pulse, issued the cycle after the last destination write, with `busy` low.
- R2: At row 0, column 0, every destination element is taken from the source. The source is laid out as `(ch*TH + y)*TW + x`.
- R3: At row 0 with column > 0, destination columns `x < OV` of every row come from the left store. The other columns come from the source, which is packed with row width `TW-OV` and holds destination column `x` at source column `x-OV`.
- R4: At column 0 with row > 0, destination rows `y < OV` come from the top store at strip offset 0. The other rows come from the source, which is packed with row width `TW` and holds destination row `y` at source row `y-OV`.
- R5: At row > 0 and column > 0, columns `x < OV` come from the left store on every row. Rows `y < OV` of the other columns come from the top store at offset `col*(TW-OV) + x`. The rest comes from a source of `(TH-OV) x (TW-OV)` elements, offset by `(OV, OV)`.
- R6: The rightmost `OV` columns of each assembled tile, across all rows and channels, are what the next pyramid in the same row receives as its left overlap.
- R7: The bottom `OV` rows of each tile are kept at column offset `col*(TW-OV)` in a store that spans a full layer row of `NCOLS*(TW-OV)+OV` columns. The pyramid at the same column in the next row receives them.
- R8: Each tile writes exactly `CH*TH*TW` destination elements, one per cycle, at address `(ch*TH + y)*TW + x`, for every channel.
- R9: The source is read only while `busy` is high and only for fresh elements. The data returned one cycle after a read is written to the destination in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin assembling one tile |
| row_idx | input | ROW_W | Pyramid row position |
| col_idx | input | CW | Pyramid column position |
| busy | output | 1 | Assembly in progress |
| done | output | 1 | One-cycle completion pulse |
| src_rd_en | output | 1 | Source memory read enable |
| src_addr | output | DAW | Source memory read address |
| src_rdata | input | DW | Source read data, one cycle after the address |
| dst_we | output | 1 | Destination write enable |
| dst_addr | output | DAW | Destination write address |
| dst_wdata | output | DW | Destination write data |

## Verification
On every cycle, the assertions check the following:
- the single-cycle `done` pulse and that `busy` is low with it;
- the destination write count per tile;
- that addresses stay inside the tile;
- that each source read is consumed by a write in the next cycle;
- that a corner tile draws every element from the source.

Whether the overlap values land in the right places can only be shown by the bench. It streams whole frames of random intermediate maps in raster order and compares each tile with a window cut directly from the full map. This exercises the left and top stores across rows and the ignored `start` while `busy` is high.

// File: rtl/pyr_pkg.sv
package pyr_pkg;
   typedef enum logic [1:0] {
      SEL_SRC  = 2'd0,
      SEL_LEFT = 2'd1,
      SEL_TOP  = 2'd2
   } pyr_sel_e;

   function automatic int pyr_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pyr_scan.sv
module pyr_scan #(
   parameter int CH  = 2,
   parameter int TH  = 5,
   parameter int TW  = 5,
   parameter int CHW = 1,
   parameter int YW  = 3,
   parameter int XW  = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go_req,
   output logic           valid,
   output logic [CHW-1:0] ch,
   output logic [YW-1:0]  y,
   output logic [XW-1:0]  x,
   output logic           last
);
   logic run;

   assign valid = run;
   assign last  = run && (ch == CHW'(CH-1)) && (y == YW'(TH-1)) && (x == XW'(TW-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         ch  <= '0;
         y   <= '0;
         x   <= '0;
      end else if (!run) begin
         if (go_req) begin
            run <= 1'b1;
            ch  <= '0;
            y   <= '0;
            x   <= '0;
         end
      end else begin
         if (last) run <= 1'b0;
         if (x == XW'(TW-1)) begin
            x <= '0;
            if (y == YW'(TH-1)) begin
               y  <= '0;
               ch <= (ch == CHW'(CH-1)) ? '0 : ch + 1'b1;
            end else begin
               y <= y + 1'b1;
            end
         end else begin
            x <= x + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pyr_route.sv
module pyr_route
   import pyr_pkg::*;
#(
   parameter int CH    = 2,
   parameter int TH    = 5,
   parameter int TW    = 5,
   parameter int OV    = 2,
   parameter int MW    = 14,
   parameter int CW    = 2,
   parameter int CHW   = 1,
   parameter int YW    = 3,
   parameter int XW    = 3,
   parameter int DAW   = 6,
   parameter int LAW   = 5,
   parameter int TAW   = 6
) (
   input  logic [CHW-1:0] ch,
   input  logic [YW-1:0]  y,
   input  logic [XW-1:0]  x,
   input  logic           first_row,
   input  logic           first_col,
   input  logic [CW-1:0]  col,
   output pyr_sel_e       sel,
   output logic [DAW-1:0] src_addr,
   output logic [DAW-1:0] dst_addr,
   output logic [LAW-1:0] lr_addr,
   output logic           lw_en,
   output logic [LAW-1:0] lw_addr,
   output logic [TAW-1:0] tr_addr,
   output logic           tw_en,
   output logic [TAW-1:0] tw_addr
);
   localparam int SX = TW - OV;
   localparam int SY = TH - OV;

   int ci, yi, xi, cx0, cy0, sw, sh, base;

   always_comb begin
      ci   = int'(ch);
      yi   = int'(y);
      xi   = int'(x);
      cx0  = first_col ? 0 : OV;
      cy0  = first_row ? 0 : OV;
      sw   = TW - cx0;
      sh   = TH - cy0;
      base = int'(col) * SX;

      if (!first_col && xi < OV)      sel = SEL_LEFT;
      else if (!first_row && yi < OV) sel = SEL_TOP;
      else                            sel = SEL_SRC;

      src_addr = DAW'(ci*sh*sw + (yi-cy0)*sw + (xi-cx0));
      dst_addr = DAW'((ci*TH + yi)*TW + xi);
      lr_addr  = LAW'((ci*TH + yi)*OV + xi);
      lw_en    = (xi >= SX);
      lw_addr  = LAW'((ci*TH + yi)*OV + (xi - SX));
      tr_addr  = TAW'((ci*OV + yi)*MW + base + xi);
      tw_en    = (yi >= SY);
      tw_addr  = TAW'((ci*OV + (yi - SY))*MW + base + xi);
   end
endmodule

// File: rtl/pyr_ram.sv
module pyr_ram #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pyr_tile_assembler.sv
module pyr_tile_assembler
   import pyr_pkg::*;
#(
   parameter int DW    = 8,
   parameter int CH    = 2,
   parameter int KER   = 3,
   parameter int STR   = 1,
   parameter int TH    = 5,
   parameter int TW    = 5,
   parameter int NCOLS = 4,
   parameter int ROW_W = 8,
   localparam int OV   = KER - STR,
   localparam int MW   = NCOLS*(TW-OV) + OV,
   localparam int TILE = CH*TH*TW,
   localparam int DAW  = pyr_w(TILE),
   localparam int CW   = pyr_w(NCOLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ROW_W-1:0] row_idx,
   input  logic [CW-1:0]    col_idx,
   output logic             busy,
   output logic             done,
   output logic             src_rd_en,
   output logic [DAW-1:0]   src_addr,
   input  logic [DW-1:0]    src_rdata,
   output logic             dst_we,
   output logic [DAW-1:0]   dst_addr,
   output logic [DW-1:0]    dst_wdata
);
   localparam int LDEP = CH*TH*OV;
   localparam int TDEP = CH*OV*MW;
   localparam int LAW  = pyr_w(LDEP);
   localparam int TAW  = pyr_w(TDEP);
   localparam int CHW  = pyr_w(CH);
   localparam int YW   = pyr_w(TH);
   localparam int XW   = pyr_w(TW);

   if (OV < 1)     begin : g_bad_ov   $error("KER must exceed STR"); end
   if (TH <= OV)   begin : g_bad_th   $error("TH must exceed KER-STR"); end
   if (TW <= OV)   begin : g_bad_tw   $error("TW must exceed KER-STR"); end
   if (NCOLS < 2)  begin : g_bad_nc   $error("NCOLS must be at least 2"); end

   logic           accept, v0, last0, first_row, first_col;
   logic [CW-1:0]  col_q;
   logic [CHW-1:0] ch0;
   logic [YW-1:0]  y0;
   logic [XW-1:0]  x0;
   pyr_sel_e       sel0, sel1;
   logic [DAW-1:0] dst_addr0, dst_addr1;
   logic [LAW-1:0] lr_addr0, lw_addr0, lw_addr1;
   logic [TAW-1:0] tr_addr0, tw_addr0, tw_addr1;
   logic           lw_en0, tw_en0, lw_en1, tw_en1, v1, last1;
   logic [DW-1:0]  left_rdata, top_rdata;

   assign accept = start && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_row <= 1'b1;
         first_col <= 1'b1;
         col_q     <= '0;
      end else if (accept) begin
         first_row <= (row_idx == '0);
         first_col <= (col_idx == '0);
         col_q     <= col_idx;
      end
   end

   pyr_scan #(.CH(CH), .TH(TH), .TW(TW), .CHW(CHW), .YW(YW), .XW(XW)) u_scan (
      .clk(clk), .rst_n(rst_n), .go_req(accept),
      .valid(v0), .ch(ch0), .y(y0), .x(x0), .last(last0)
   );

   pyr_route #(.CH(CH), .TH(TH), .TW(TW), .OV(OV), .MW(MW), .CW(CW), .CHW(CHW),
               .YW(YW), .XW(XW), .DAW(DAW), .LAW(LAW), .TAW(TAW)) u_route (
      .ch(ch0), .y(y0), .x(x0), .first_row(first_row), .first_col(first_col),
      .col(col_q), .sel(sel0), .src_addr(src_addr), .dst_addr(dst_addr0),
      .lr_addr(lr_addr0), .lw_en(lw_en0), .lw_addr(lw_addr0),
      .tr_addr(tr_addr0), .tw_en(tw_en0), .tw_addr(tw_addr0)
   );

   assign src_rd_en = v0 && (sel0 == SEL_SRC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1    <= 1'b0;
         last1 <= 1'b0;
         done  <= 1'b0;
      end else begin
         v1    <= v0;
         last1 <= last0;
         done  <= v1 && last1;
      end
   end

   always_ff @(posedge clk) begin
      sel1      <= sel0;
      dst_addr1 <= dst_addr0;
      lw_en1    <= lw_en0;
      lw_addr1  <= lw_addr0;
      tw_en1    <= tw_en0;
      tw_addr1  <= tw_addr0;
   end

   always_comb begin
      unique case (sel1)
         SEL_LEFT: dst_wdata = left_rdata;
         SEL_TOP:  dst_wdata = top_rdata;
         default:  dst_wdata = src_rdata;
      endcase
   end

   assign dst_we   = v1;
   assign dst_addr = dst_addr1;
   assign busy     = v0 || v1;

   pyr_ram #(.DEPTH(LDEP), .DW(DW), .AW(LAW)) u_left (
      .clk(clk), .we(v1 && lw_en1), .waddr(lw_addr1), .wdata(dst_wdata),
      .re(v0), .raddr(lr_addr0), .rdata(left_rdata)
   );

   pyr_ram #(.DEPTH(TDEP), .DW(DW), .AW(TAW)) u_top (
      .clk(clk), .we(v1 && tw_en1), .waddr(tw_addr1), .wdata(dst_wdata),
      .re(v0), .raddr(tr_addr0), .rdata(top_rdata)
   );
endmodule

// File: rtl/pyr_tile_assembler_chk.sv
module pyr_tile_assembler_chk #(
   parameter int CH    = 2,
   parameter int TH    = 5,
   parameter int TW    = 5,
   parameter int ROW_W = 8,
   parameter int CW    = 2,
   parameter int DAW   = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [ROW_W-1:0] row_idx,
   input logic [CW-1:0]    col_idx,
   input logic             busy,
   input logic             done,
   input logic             src_rd_en,
   input logic             dst_we,
   input logic [DAW-1:0]   dst_addr
);
   localparam int TILE = CH*TH*TW;

   int   wcnt;
   logic corner;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcnt   <= 0;
         corner <= 1'b0;
      end else if (start && !busy) begin
         wcnt   <= 0;
         corner <= (row_idx == '0) && (col_idx == '0);
      end else if (dst_we) begin
         wcnt <= wcnt + 1;
      end
   end

   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_corner_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (corner && dst_we) |-> $past(src_rd_en));
   p_write_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wcnt == TILE));
   p_dst_in_tile_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> (int'(dst_addr) < TILE));
   p_src_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(src_rd_en) |-> dst_we);
   p_src_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      src_rd_en |-> busy);
endmodule

bind pyr_tile_assembler pyr_tile_assembler_chk #(
   .CH(CH), .TH(TH), .TW(TW), .ROW_W(ROW_W), .CW(CW), .DAW(DAW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .row_idx(row_idx), .col_idx(col_idx),
   .busy(busy), .done(done), .src_rd_en(src_rd_en), .dst_we(dst_we), .dst_addr(dst_addr)
);

// File: tb/sim_pyr_tile_assembler.sv
module sim_pyr_tile_assembler;
   localparam int DW = 8, CH = 2, KER = 3, STR = 1, TH = 5, TW = 5, NCOLS = 4, NROWS = 3;
   localparam int OV = KER - STR;
   localparam int SX = TW - OV, SY = TH - OV;
   localparam int MW = NCOLS*SX + OV;
   localparam int MH = NROWS*SY + OV;
   localparam int TILE = CH*TH*TW;
   localparam int DAW = $clog2(TILE);
   localparam int CW = $clog2(NCOLS);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [7:0] row_idx = '0;
   logic [CW-1:0] col_idx = '0;
   logic busy, done, src_rd_en, dst_we;
   logic [DAW-1:0] src_addr, dst_addr;
   logic [DW-1:0] src_rdata, dst_wdata;

   logic [DW-1:0] srcmem [TILE];
   logic [DW-1:0] dstmem [TILE];
   int mapv [CH*MH*MW];
   int errors = 0, checks = 0, wcnt = 0, cycles = 0;

   always #4 clk = ~clk;

   pyr_tile_assembler #(.DW(DW), .CH(CH), .KER(KER), .STR(STR), .TH(TH), .TW(TW),
                        .NCOLS(NCOLS), .ROW_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .row_idx(row_idx), .col_idx(col_idx),
      .busy(busy), .done(done), .src_rd_en(src_rd_en), .src_addr(src_addr),
      .src_rdata(src_rdata), .dst_we(dst_we), .dst_addr(dst_addr), .dst_wdata(dst_wdata)
   );

   always @(posedge clk) begin
      if (src_rd_en) src_rdata <= srcmem[src_addr];
      if (dst_we) dstmem[dst_addr] <= dst_wdata;
   end

   always @(negedge clk) begin
      cycles++;
      if (dst_we) wcnt++;
      if (cycles > 150000) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int midx(int c, int yy, int xx);
      return (c*MH + yy)*MW + xx;
   endfunction

   function automatic string req_of(int r, int c);
      if (r == 0 && c == 0) return "R2";
      if (r == 0)           return "R3/R6";
      if (c == 0)           return "R4/R7";
      return "R5/R6/R7";
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_tile(input int r, input int c, input bit poke);
      int cx0, cy0, sw, sh, bad_act, bad_exp, guard;
      bit ok;
      cx0 = (c == 0) ? 0 : OV;
      cy0 = (r == 0) ? 0 : OV;
      sw = TW - cx0;
      sh = TH - cy0;
      for (int i = 0; i < TILE; i++) srcmem[i] = 8'hEE;
      for (int k = 0; k < CH; k++)
         for (int yy = 0; yy < sh; yy++)
            for (int xx = 0; xx < sw; xx++)
               srcmem[k*sh*sw + yy*sw + xx] = DW'(mapv[midx(k, r*SY + cy0 + yy, c*SX + cx0 + xx)]);
      @(negedge clk);
      row_idx = 8'(r); col_idx = CW'(c); start = 1'b1;
      @(negedge clk);
      start = 1'b0; wcnt = 0;
      if (poke) begin
         repeat (3) @(negedge clk);
         row_idx = '0; col_idx = '0; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (!done && guard < 2000) begin @(negedge clk); guard++; end
      check(guard < 2000, "R1 done", guard, TILE + 2);
      ok = 1'b1; bad_act = 0; bad_exp = 0;
      for (int k = 0; k < CH; k++)
         for (int yy = 0; yy < TH; yy++)
            for (int xx = 0; xx < TW; xx++)
               if (ok && int'(dstmem[(k*TH + yy)*TW + xx]) != mapv[midx(k, r*SY + yy, c*SX + xx)]) begin
                  ok = 1'b0;
                  bad_act = int'(dstmem[(k*TH + yy)*TW + xx]);
                  bad_exp = mapv[midx(k, r*SY + yy, c*SX + xx)];
               end
      check(ok, poke ? "R1 start ignored while busy" : req_of(r, c), bad_act, bad_exp);
      check(wcnt == TILE, "R8 write count", wcnt, TILE);
      @(negedge clk);
      check(!done, "R1 done single pulse", int'(done), 0);
   endtask

   task automatic frame(input int kind, input bit poke_mid);
      for (int k = 0; k < CH; k++)
         for (int yy = 0; yy < MH; yy++)
            for (int xx = 0; xx < MW; xx++)
               mapv[midx(k, yy, xx)] = (kind == 0) ? ((k*97 + yy*13 + xx) & 8'hFF)
                                                   : int'($urandom() & 32'hFF);
      for (int r = 0; r < NROWS; r++)
         for (int c = 0; c < NCOLS; c++)
            run_tile(r, c, poke_mid && r == 1 && c == 1);
   endtask

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy, "R1 reset busy", int'(busy), 0);
      check(!done && !dst_we && !src_rd_en, "R1 reset outputs", int'(done | dst_we | src_rd_en), 0);
      frame(0, 1'b0);
      frame(1, 1'b1);
      frame(1, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule